// File: doc/BRIEF.md
# Ten-Region Two-Wire Memory Slave

This block is the serial slave front end of a device that keeps ten separate 256-byte memory regions on one two-wire (I2C-style) bus. Eight regions are general scratchpad storage. One region holds clock settings that survive power loss. One region holds clock settings that do not. Each region answers to its own 7-bit device address. The block oversamples the bus with its own system clock. It detects start and stop conditions, decodes the device byte, the word address and the data bytes, and drives acknowledges and read data by pulling the data line low.

A write-protect input guards the eight scratchpad regions and the nonvolatile settings region. The volatile settings region stays writable at all times. A mode input says whether the shared pin is used for write protect at all; when it is not, the protect level is ignored. A byte whose write was blocked is still acknowledged, so the bus sequence looks the same to a master either way. Storage is modelled as plain byte arrays, with no programming delay.

Top module: `twm_slave`

## Requirements
- R1: The slave acknowledges (pulls data low in the ninth clock) a device byte whose upper seven bits equal one of the ten region addresses: 0x50 to 0x57 for scratchpad regions 0 to 7, 0x69 for the nonvolatile settings region, 0x6A for the volatile settings region. Bit 0 of the device byte is the read/write flag, with 1 meaning read.
- R2: A device byte with any other address gets no acknowledge. The slave then ignores the bus until the next start, so a following byte is not acknowledged either.
- R3: In a write transfer the byte after the device byte is loaded as the word address, and each later byte is stored at the current word address of the addressed region.
- R4: The word address advances by one after every written or read byte and wraps from 255 to 0 within the same region.
- R5: A read returns bytes from the current word address onward. A master acknowledge continues the read. A master no-acknowledge ends it, and the slave leaves the data line released.
- R6: While the write-protect input is high and the mode input selects write protect (mode = 1), writes to the scratchpad regions and the nonvolatile settings region leave their stored bytes unchanged.
- R7: The volatile settings region accepts writes while write protect is high.
- R8: While the write-protect input is low, writes to every region take effect.
- R9: While the mode input is 0 (pin used for analog control), the write-protect level has no effect and all writes take effect.
- R10: A data byte whose write was blocked by write protect is still acknowledged.
- R11: Reads from every region return stored data while write protect is active.
- R12: During reset, and right after it, the slave leaves the data line released.
- R13: Regions are independent: the same word address in two regions holds two different bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_drive_low_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| wp_i | input | 1 | Write-protect level, high blocks nonvolatile writes |
| wp_mode_i | input | 1 | 1: shared pin acts as write protect; 0: pin used for analog control, protect ignored |

## Verification
The bench targets the word address wrap at 255 during a multi-byte write and the following read. An off-by-one or an unwrapped counter there would put the third byte in the wrong place or in a neighbouring region. It tries addresses just outside the decoded set, such as 0x58 and 0x6B. A loose decoder would acknowledge them and then also acknowledge the stray byte that follows. Under write protect it checks three things: the volatile settings region must still change; protect must be ignored when the pin is in analog mode; and a blocked byte must still be acknowledged. A design that tested the region type backwards or skipped the mode bit would keep a byte it should drop, or drop one it should keep. A design that withheld the acknowledge would show up as a missing ack. The read that ends in a no-acknowledge checks that the slave lets go of the line rather than driving the next byte.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_WADDR,
    S_WADDR_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_RACK
  } twm_state_e;
endpackage

// File: rtl/twm_rst_sync.sv
module twm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = pipe_q[STAGES-1];
endmodule

// File: rtl/twm_bus_sampler.sv
module twm_bus_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twm_addr_decode.sv
module twm_addr_decode #(
  parameter int unsigned N_SCRATCH    = 8,
  parameter logic [6:0]  SCRATCH_BASE = 7'h50,
  parameter logic [6:0]  NV_CFG_ADDR  = 7'h69,
  parameter logic [6:0]  V_CFG_ADDR   = 7'h6A,
  localparam int unsigned NREG        = N_SCRATCH + 2,
  localparam int unsigned RW          = $clog2(NREG)
) (
  input  logic [6:0]    dev_addr,
  output logic          hit,
  output logic [RW-1:0] idx
);
  logic [NREG-1:0] match;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    localparam logic [6:0] REGION_ADDR =
      (g < N_SCRATCH)  ? 7'(SCRATCH_BASE + 7'(g)) :
      (g == N_SCRATCH) ? NV_CFG_ADDR : V_CFG_ADDR;
    assign match[g] = (dev_addr == REGION_ADDR);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (match[i]) idx = RW'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/twm_region_mem.sv
module twm_region_mem #(
  parameter int unsigned NREG  = 10,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned RW   = $clog2(NREG),
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] region,
  input  logic [PW-1:0] ptr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [NREG*DEPTH];
  logic [RW+PW-1:0] flat_idx;

  assign flat_idx = {region, ptr};

  always_ff @(posedge clk) begin
    if (we) mem[flat_idx] <= wdata;
  end

  assign rdata = mem[flat_idx];
endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter int unsigned N_SCRATCH    = 8,
  parameter int unsigned DEPTH        = 256,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter logic [6:0]  SCRATCH_BASE = 7'h50,
  parameter logic [6:0]  NV_CFG_ADDR  = 7'h69,
  parameter logic [6:0]  V_CFG_ADDR   = 7'h6A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_drive_low_o,
  input  logic wp_i,
  input  logic wp_mode_i
);
  localparam int unsigned NREG = N_SCRATCH + 2;
  localparam int unsigned RW   = $clog2(NREG);
  localparam int unsigned PW   = $clog2(DEPTH);
  localparam logic [RW-1:0] VOL_IDX = RW'(N_SCRATCH + 1);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic rst_sn;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic dec_hit;
  logic [RW-1:0] dec_idx;
  logic [7:0] rd_data;

  twm_state_e     state_q, state_n;
  logic [3:0]     bitcnt_q, bitcnt_n;
  logic [7:0]     shreg_q, shreg_n;
  logic [PW-1:0]  ptr_q, ptr_n;
  logic [RW-1:0]  region_q, region_n;
  logic           rw_q, rw_n;
  logic           drv_q, drv_n;
  logic           mack_q, mack_n;
  logic           mem_we, ptr_inc, wr_allow, region_vol;

  twm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  twm_bus_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_sn(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twm_addr_decode #(
    .N_SCRATCH(N_SCRATCH), .SCRATCH_BASE(SCRATCH_BASE),
    .NV_CFG_ADDR(NV_CFG_ADDR), .V_CFG_ADDR(V_CFG_ADDR)
  ) u_dec (
    .dev_addr(shreg_q[7:1]), .hit(dec_hit), .idx(dec_idx)
  );

  twm_region_mem #(.NREG(NREG), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .region(region_q), .ptr(ptr_q),
    .wdata(shreg_q), .rdata(rd_data)
  );

  // Protect applies only in protect mode and only to nonvolatile regions.
  assign region_vol = (region_q == VOL_IDX);
  assign wr_allow   = ~(wp_i & wp_mode_i) | region_vol;

  always_comb begin
    state_n  = state_q;
    bitcnt_n = bitcnt_q;
    shreg_n  = shreg_q;
    ptr_n    = ptr_q;
    region_n = region_q;
    rw_n     = rw_q;
    drv_n    = drv_q;
    mack_n   = mack_q;
    mem_we   = 1'b0;
    ptr_inc  = 1'b0;

    if (stop_det) begin
      state_n = S_IDLE;
      drv_n   = 1'b0;
    end else if (start_det) begin
      state_n  = S_DEV;
      bitcnt_n = '0;
      drv_n    = 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: ;
        S_DEV, S_WADDR, S_WDATA: begin
          if (scl_rise && bitcnt_q < LAST_BIT) begin
            shreg_n  = {shreg_q[6:0], sda_s};
            bitcnt_n = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == LAST_BIT) begin
            bitcnt_n = '0;
            if (state_q == S_DEV) begin
              if (dec_hit) begin
                region_n = dec_idx;
                rw_n     = shreg_q[0];
                drv_n    = 1'b1;
                state_n  = S_DEV_ACK;
              end else begin
                state_n  = S_IDLE;
              end
            end else if (state_q == S_WADDR) begin
              ptr_n   = shreg_q[PW-1:0];
              drv_n   = 1'b1;
              state_n = S_WADDR_ACK;
            end else begin
              mem_we  = wr_allow;
              ptr_n   = ptr_q + 1'b1;
              ptr_inc = 1'b1;
              drv_n   = 1'b1;
              state_n = S_WDATA_ACK;
            end
          end
        end
        S_DEV_ACK, S_WADDR_ACK, S_WDATA_ACK: begin
          if (scl_fall) begin
            drv_n    = 1'b0;
            bitcnt_n = '0;
            if (state_q == S_DEV_ACK && rw_q) begin
              shreg_n = rd_data;
              drv_n   = ~rd_data[7];
              state_n = S_RDATA;
            end else if (state_q == S_DEV_ACK) begin
              state_n = S_WADDR;
            end else begin
              state_n = S_WDATA;
            end
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            if (bitcnt_q == LAST_BIT - 4'd1) begin
              drv_n    = 1'b0;
              bitcnt_n = '0;
              ptr_n    = ptr_q + 1'b1;
              ptr_inc  = 1'b1;
              state_n  = S_RACK;
            end else begin
              bitcnt_n = bitcnt_q + 4'd1;
              shreg_n  = {shreg_q[6:0], 1'b0};
              drv_n    = ~shreg_q[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              shreg_n = rd_data;
              drv_n   = ~rd_data[7];
              state_n = S_RDATA;
            end else begin
              state_n = S_IDLE;
            end
          end
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= S_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      region_q <= '0;
      rw_q     <= 1'b0;
      drv_q    <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      bitcnt_q <= bitcnt_n;
      shreg_q  <= shreg_n;
      ptr_q    <= ptr_n;
      region_q <= region_n;
      rw_q     <= rw_n;
      drv_q    <= drv_n;
      mack_q   <= mack_n;
    end
  end

  assign sda_drive_low_o = drv_q;
endmodule

// File: rtl/twm_slave_chk.sv
module twm_slave_chk
  import twm_pkg::*;
#(
  parameter int unsigned PW = 8
) (
  input logic       clk,
  input logic       rst_sn,
  input logic       start_det,
  input logic       stop_det,
  input twm_state_e state_q,
  input logic       sda_drive_low_o,
  input logic       mem_we,
  input logic       wp_i,
  input logic       wp_mode_i,
  input logic       region_vol,
  input logic [PW-1:0] ptr_q,
  input logic       ptr_inc
);
  p_release_after_reset_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(rst_sn) |-> !sda_drive_low_o);

  p_drive_in_slave_slots_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    sda_drive_low_o |-> (state_q inside {S_DEV_ACK, S_WADDR_ACK, S_WDATA_ACK, S_RDATA}));

  p_start_to_device_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_det && !stop_det) |=> (state_q == S_DEV) && !sda_drive_low_o);

  p_stop_releases_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    stop_det |=> (state_q == S_IDLE) && !sda_drive_low_o);

  p_protect_blocks_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_we && wp_i && wp_mode_i) |-> region_vol);

  p_ptr_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    ptr_inc |=> ptr_q == PW'($past(ptr_q) + 1'b1));
endmodule

bind twm_slave twm_slave_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .start_det(start_det), .stop_det(stop_det),
  .state_q(state_q), .sda_drive_low_o(sda_drive_low_o), .mem_we(mem_we),
  .wp_i(wp_i), .wp_mode_i(wp_mode_i), .region_vol(region_vol),
  .ptr_q(ptr_q), .ptr_inc(ptr_inc)
);

// File: tb/sim_twm_slave.sv
module sim_twm_slave;
  localparam int Q = 8;
  localparam int NV = 8;
  // {dev[25:19], waddr[18:11], data[10:3], wp[2], mode[1], lands[0]}
  localparam logic [25:0] VEC [NV] = '{
    {7'h50, 8'h00, 8'h11, 1'b0, 1'b1, 1'b1},
    {7'h57, 8'hFF, 8'h22, 1'b0, 1'b1, 1'b1},
    {7'h53, 8'h10, 8'h33, 1'b1, 1'b1, 1'b0},
    {7'h69, 8'h20, 8'h44, 1'b1, 1'b1, 1'b0},
    {7'h6A, 8'h30, 8'h55, 1'b1, 1'b1, 1'b1},
    {7'h54, 8'h40, 8'h66, 1'b1, 1'b0, 1'b1},
    {7'h69, 8'h41, 8'h77, 1'b1, 1'b0, 1'b1},
    {7'h6A, 8'h42, 8'h88, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic wp_mode = 1'b1;
  logic drv;
  logic sda_line;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~drv;

  twm_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low_o(drv), .wp_i(wp), .wp_mode_i(wp_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(Q); scl = 1'b1; qw(Q); sda_m = 1'b0; qw(Q); scl = 1'b0; qw(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(Q); scl = 1'b1; qw(Q); sda_m = 1'b1; qw(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(Q); scl = 1'b1; qw(Q); scl = 1'b0; qw(Q);
    end
    sda_m = 1'b1; qw(Q); scl = 1'b1; qw(Q/2);
    acked = ~sda_line;
    qw(Q/2); scl = 1'b0; qw(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b1; qw(Q/2); b[i] = sda_line; qw(Q/2); scl = 1'b0; qw(Q);
    end
    sda_m = ~give_ack; qw(Q); scl = 1'b1; qw(Q); scl = 1'b0; qw(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr1(input logic [6:0] dev, input logic [7:0] wa, input logic [7:0] d,
                     output logic a0, output logic a1, output logic a2);
    bus_start();
    send_byte({dev, 1'b0}, a0);
    send_byte(wa, a1);
    send_byte(d, a2);
    bus_stop();
  endtask

  task automatic rd1(input logic [6:0] dev, input logic [7:0] wa, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte({dev, 1'b0}, a);
    send_byte(wa, a);
    bus_start();
    send_byte({dev, 1'b1}, a);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] d;

    qw(5);
    chk("R12 line released in reset", drv, 1'b0);
    rst_n = 1'b1;
    qw(10);
    chk("R12 line released after reset", drv, 1'b0);

    // Vector table: baseline write, attempt under protect settings, readback.
    for (int v = 0; v < NV; v++) begin
      logic [6:0] dev;
      logic [7:0] wa, dat, got;
      dev = VEC[v][25:19]; wa = VEC[v][18:11]; dat = VEC[v][10:3];
      wp = 1'b0; wp_mode = 1'b1;
      wr1(dev, wa, 8'hA5, a0, a1, a2);
      wp = VEC[v][2]; wp_mode = VEC[v][1];
      wr1(dev, wa, dat, a0, a1, a2);
      chk($sformatf("R1 device ack vec %0d", v), a0, 1'b1);
      chk($sformatf("R3 word address ack vec %0d", v), a1, 1'b1);
      chk($sformatf("R10 data ack vec %0d", v), a2, 1'b1);
      rd1(dev, wa, got);
      chk($sformatf("R6 R7 R8 R9 R11 stored byte vec %0d", v), got,
          VEC[v][0] ? dat : 8'hA5);
    end
    wp = 1'b0; wp_mode = 1'b1;

    // R1: every region address acknowledged.
    for (int r = 0; r < 10; r++) begin
      logic [6:0] dev;
      dev = (r < 8) ? 7'(7'h50 + r) : ((r == 8) ? 7'h69 : 7'h6A);
      bus_start(); send_byte({dev, 1'b0}, a0); bus_stop();
      chk($sformatf("R1 ack for address %0h", dev), a0, 1'b1);
    end

    // R2: addresses just outside the set, and the following byte.
    bus_start(); send_byte({7'h58, 1'b0}, a0); send_byte(8'h00, a1); bus_stop();
    chk("R2 no ack for 0x58", a0, 1'b0);
    chk("R2 no ack for byte after miss", a1, 1'b0);
    bus_start(); send_byte({7'h6B, 1'b1}, a0); bus_stop();
    chk("R2 no ack for 0x6B", a0, 1'b0);
    chk("R2 line released after miss", drv, 1'b0);

    // R4 R5: burst write across the wrap, then burst read.
    bus_start();
    send_byte({7'h51, 1'b0}, a0);
    send_byte(8'hFE, a0);
    send_byte(8'hC1, a0); send_byte(8'hC2, a1); send_byte(8'hC3, a2);
    bus_stop();
    chk("R4 burst data acks", {a0, a1, a2}, 3'b111);
    rd1(7'h51, 8'h00, d);
    chk("R4 wrapped byte at address 0", d, 8'hC3);
    bus_start();
    send_byte({7'h51, 1'b0}, a0);
    send_byte(8'hFE, a0);
    bus_start();
    send_byte({7'h51, 1'b1}, a0);
    recv_byte(1'b1, d); chk("R5 read byte 0xFE", d, 8'hC1);
    recv_byte(1'b1, d); chk("R5 read byte 0xFF", d, 8'hC2);
    recv_byte(1'b0, d); chk("R4 R5 read wraps to 0x00", d, 8'hC3);
    chk("R5 line released after master no-ack", drv, 1'b0);
    bus_stop();

    // R13: same word address in two regions.
    wr1(7'h52, 8'h05, 8'h5A, a0, a1, a2);
    wr1(7'h6A, 8'h05, 8'hA6, a0, a1, a2);
    rd1(7'h52, 8'h05, d);
    chk("R13 scratch region 2 keeps its byte", d, 8'h5A);
    rd1(7'h6A, 8'h05, d);
    chk("R13 volatile region keeps its byte", d, 8'hA6);

    // R6 R10: blocked burst into nonvolatile settings region under protect.
    wr1(7'h69, 8'h80, 8'h3C, a0, a1, a2);
    wp = 1'b1;
    wr1(7'h69, 8'h80, 8'hC3, a0, a1, a2);
    chk("R10 blocked byte still acked", a2, 1'b1);
    rd1(7'h69, 8'h80, d);
    chk("R6 R11 protected byte unchanged", d, 8'h3C);
    wp = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule